// File: doc/BRIEF.md
# Per-Core DRAM Access Profiler

This block sits beside a memory controller and observes every DRAM request that the controller services. Each request carries the issuing core's index, its channel, rank and bank coordinates, and its row address. For every core the block counts the requests seen in the current profiling window. It also counts how many of those requests would have hit an open row if that core had the DRAM to itself. To judge this it keeps, for each core and each bank, a private copy of the last row that core touched there, so traffic from other cores never disturbs the measurement.

A free-running timer divides time into windows of fixed length. When a window closes, the block sorts each core into one of three behaviour classes from its two counts. It copies the counts and classes into holding registers, which stay constant for the whole of the next window, and it raises a one-cycle pulse. The live counters restart from zero. A downstream partitioning or scheduling policy reads the held values; that policy is not part of this block.

Top module: `mem_behavior_profiler`

## Requirements
- R1: `window_done` is high for exactly one cycle every `WINDOW` clock cycles. Its first assertion comes on the `WINDOW`-th rising edge after reset is released.
- R2: The access count of core c in a window equals the number of cycles in that window in which `req_valid` was high with `req_core` equal to c. Cycles with `req_valid` low are not counted.
- R3: A request is a private-row hit when its row equals the row of that same core's previous request to the same (channel, rank, bank). After each request that entry holds the request's row. Requests from other cores to the same bank leave the entry unchanged.
- R4: After reset every private-row entry is empty, so the first request of a core to a bank is never a hit. Entries keep their contents across window boundaries.
- R5: Class code per core, computed from the window's counts: 0 (light) when accesses < `MIN_ACCESSES`; otherwise 1 (scattered) when 2×hits < accesses; otherwise 2 (row-local). A core with 2×hits exactly equal to accesses is therefore class 2.
- R6: Held counts and classes change only on the cycle `window_done` rises. Reset sets every held count to 0 and every class to 0.
- R7: A request sampled on the same clock edge that closes a window is counted in the new window, not the closing one.
- R8: In the flattened outputs, core i occupies `held_accesses[i*CNT_W +: CNT_W]`, `held_hits[i*CNT_W +: CNT_W]` and `held_class[2*i +: 2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A serviced request is present this cycle |
| req_core | input | CORE_W | Index of the issuing core |
| req_chan | input | CHAN_W | Channel of the request |
| req_rank | input | RANK_W | Rank within the channel |
| req_bank | input | BANK_W | Bank within the rank |
| req_row | input | ROW_W | Row address of the request |
| window_done | output | 1 | One-cycle pulse; held values were just updated |
| held_class | output | 2*N_CORES | Per-core behaviour class of the last closed window |
| held_accesses | output | N_CORES*CNT_W | Per-core access counts of the last closed window |
| held_hits | output | N_CORES*CNT_W | Per-core private-row hit counts of the last closed window |

## Verification
A request sampled on a rising edge affects the live counters at once. It shows up at the ports only when its window closes. The held outputs and `window_done` both change on the closing edge, so the bench reads them on the falling edge right after it, where the pulse is visible. A separate monitor counts falling edges between pulses to check the window length, including the first window after reset. In the middle of quiet windows the bench compares the held outputs with the previous window's values. It places one request exactly on a closing edge and checks that it appears in the following window's counts.

// File: rtl/prof_pkg.sv
package prof_pkg;

    typedef enum logic [1:0] {
        CLS_LIGHT   = 2'd0,
        CLS_SCATTER = 2'd1,
        CLS_LOCAL   = 2'd2
    } core_class_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Divider-free classification: 2*hits is compared against accesses.
    function automatic core_class_e classify(input logic [31:0] acc,
                                             input logic [31:0] hits,
                                             input logic [31:0] min_acc);
        logic [32:0] twice_hits;
        twice_hits = {hits, 1'b0};
        if (acc < min_acc) begin
            return CLS_LIGHT;
        end
        if (twice_hits < {1'b0, acc}) begin
            return CLS_SCATTER;
        end
        return CLS_LOCAL;
    endfunction

endpackage

// File: rtl/prof_interval_timer.sv
module prof_interval_timer #(
    parameter  int unsigned WINDOW = 100000,
    localparam int unsigned TW     = prof_pkg::idx_width(WINDOW)
) (
    input  logic clk,
    input  logic rst,
    output logic roll_o,
    output logic end_o
);
    logic [TW-1:0] cnt_q;

    assign roll_o = (32'(cnt_q) == WINDOW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            end_o <= 1'b0;
        end else begin
            end_o <= roll_o;
            cnt_q <= roll_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: the position counter never leaves the window
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < WINDOW);

    generate
        if (WINDOW > 1) begin : g_pulse_chk
            // R1: the window-end pulse is a single cycle wide
            p_end_lone_r1: assert property (@(posedge clk) disable iff (rst)
                end_o |=> !end_o);
        end
    endgenerate

endmodule

// File: rtl/prof_shadow_table.sv
module prof_shadow_table #(
    parameter  int unsigned N_CORES = 8,
    parameter  int unsigned N_SLOTS = 32,
    parameter  int unsigned ROW_W   = 16,
    localparam int unsigned CORE_W  = prof_pkg::idx_width(N_CORES),
    localparam int unsigned SLOT_W  = prof_pkg::idx_width(N_SLOTS),
    localparam int unsigned ENT     = N_CORES * N_SLOTS,
    localparam int unsigned ENT_W   = prof_pkg::idx_width(ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [CORE_W-1:0] core_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic              hit_o
);
    logic [ROW_W-1:0] row_q [ENT];
    logic [ENT-1:0]   vld_q;
    logic [ENT_W-1:0] idx;

    assign idx   = ENT_W'(32'(core_i) * N_SLOTS + 32'(slot_i));
    assign hit_o = req_valid_i && vld_q[idx] && (row_q[idx] == row_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (req_valid_i) begin
            vld_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (req_valid_i) begin
            row_q[idx] <= row_i;
        end
    end

    // R3: an immediate repeat of the same core, bank and row must hit
    p_repeat_hits_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !$past(rst) && $past(req_valid_i) &&
         core_i == $past(core_i) && slot_i == $past(slot_i) &&
         row_i == $past(row_i)) |-> hit_o);

    // R4: nothing is remembered across reset
    p_first_miss_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit_o);

endmodule

// File: rtl/prof_core_counters.sv
module prof_core_counters #(
    parameter  int unsigned N_CORES  = 8,
    parameter  int unsigned CNT_W    = 17,
    parameter  int unsigned MIN_ACC  = 200,
    localparam int unsigned CORE_W   = prof_pkg::idx_width(N_CORES)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid_i,
    input  logic [CORE_W-1:0]                     core_i,
    input  logic                                  hit_i,
    input  logic                                  roll_i,
    output logic [N_CORES-1:0][CNT_W-1:0]         acc_hold_o,
    output logic [N_CORES-1:0][CNT_W-1:0]         hit_hold_o,
    output prof_pkg::core_class_e [N_CORES-1:0]   cls_hold_o
);
    import prof_pkg::*;

    generate
        for (genvar g = 0; g < N_CORES; g++) begin : g_core
            logic [CNT_W-1:0] acc_live_q;
            logic [CNT_W-1:0] hit_live_q;
            logic             inc;
            logic             hinc;

            assign inc  = req_valid_i && (core_i == CORE_W'(g));
            assign hinc = inc && hit_i;

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_live_q    <= '0;
                    hit_live_q    <= '0;
                    acc_hold_o[g] <= '0;
                    hit_hold_o[g] <= '0;
                    cls_hold_o[g] <= CLS_LIGHT;
                end else if (roll_i) begin
                    acc_hold_o[g] <= acc_live_q;
                    hit_hold_o[g] <= hit_live_q;
                    cls_hold_o[g] <= classify(32'(acc_live_q), 32'(hit_live_q), MIN_ACC);
                    acc_live_q    <= CNT_W'(inc);
                    hit_live_q    <= CNT_W'(hinc);
                end else begin
                    acc_live_q    <= acc_live_q + CNT_W'(inc);
                    hit_live_q    <= hit_live_q + CNT_W'(hinc);
                end
            end

            // R3: hits are a subset of accesses
            p_hits_le_acc_r3: assert property (@(posedge clk) disable iff (rst)
                hit_live_q <= acc_live_q);

            // R7: a fresh window holds at most the request of its opening edge
            p_fresh_window_r7: assert property (@(posedge clk) disable iff (rst)
                $past(roll_i) |-> acc_live_q <= CNT_W'(1));

            // R6: held values move only on a window close
            p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
                !$past(roll_i) |-> ($stable(acc_hold_o[g]) && $stable(hit_hold_o[g]) &&
                                    $stable(cls_hold_o[g])));
        end
    endgenerate

endmodule

// File: rtl/mem_behavior_profiler.sv
module mem_behavior_profiler #(
    parameter  int unsigned N_CORES      = 8,
    parameter  int unsigned N_CHAN       = 2,
    parameter  int unsigned N_RANK       = 2,
    parameter  int unsigned N_BANK       = 8,
    parameter  int unsigned ROW_W        = 16,
    parameter  int unsigned WINDOW       = 100000,
    parameter  int unsigned MIN_ACCESSES = 200,
    localparam int unsigned CORE_W       = prof_pkg::idx_width(N_CORES),
    localparam int unsigned CHAN_W       = prof_pkg::idx_width(N_CHAN),
    localparam int unsigned RANK_W       = prof_pkg::idx_width(N_RANK),
    localparam int unsigned BANK_W       = prof_pkg::idx_width(N_BANK),
    localparam int unsigned CNT_W        = $clog2(WINDOW + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [CORE_W-1:0]          req_core,
    input  logic [CHAN_W-1:0]          req_chan,
    input  logic [RANK_W-1:0]          req_rank,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic [ROW_W-1:0]           req_row,
    output logic                       window_done,
    output logic [2*N_CORES-1:0]       held_class,
    output logic [N_CORES*CNT_W-1:0]   held_accesses,
    output logic [N_CORES*CNT_W-1:0]   held_hits
);
    localparam int unsigned N_SLOTS = N_CHAN * N_RANK * N_BANK;
    localparam int unsigned SLOT_W  = prof_pkg::idx_width(N_SLOTS);

    logic                                 roll;
    logic                                 hit;
    logic [SLOT_W-1:0]                    slot;
    logic [N_CORES-1:0][CNT_W-1:0]        acc_hold;
    logic [N_CORES-1:0][CNT_W-1:0]        hit_hold;
    prof_pkg::core_class_e [N_CORES-1:0]  cls_hold;

    assign slot = SLOT_W'((32'(req_chan) * N_RANK + 32'(req_rank)) * N_BANK + 32'(req_bank));

    prof_interval_timer #(.WINDOW(WINDOW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .roll_o (roll),
        .end_o  (window_done)
    );

    prof_shadow_table #(
        .N_CORES (N_CORES),
        .N_SLOTS (N_SLOTS),
        .ROW_W   (ROW_W)
    ) u_shadow (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .core_i      (req_core),
        .slot_i      (slot),
        .row_i       (req_row),
        .hit_o       (hit)
    );

    prof_core_counters #(
        .N_CORES (N_CORES),
        .CNT_W   (CNT_W),
        .MIN_ACC (MIN_ACCESSES)
    ) u_counters (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .core_i      (req_core),
        .hit_i       (hit),
        .roll_i      (roll),
        .acc_hold_o  (acc_hold),
        .hit_hold_o  (hit_hold),
        .cls_hold_o  (cls_hold)
    );

    assign held_accesses = acc_hold;
    assign held_hits     = hit_hold;
    assign held_class    = cls_hold;

endmodule

// File: tb/mem_behavior_profiler_tb.sv
`timescale 1ns/1ps
module mem_behavior_profiler_tb;
    localparam int NC = 2, NCH = 1, NR = 2, NB = 2, RW = 3, IV = 32, TH = 4;
    localparam int CW = $clog2(IV + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [0:0] req_core = '0, req_chan = '0, req_rank = '0, req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic window_done;
    logic [2*NC-1:0] held_class;
    logic [NC*CW-1:0] held_accesses, held_hits;

    always #2.5 clk = ~clk;

    mem_behavior_profiler #(.N_CORES(NC), .N_CHAN(NCH), .N_RANK(NR), .N_BANK(NB),
        .ROW_W(RW), .WINDOW(IV), .MIN_ACCESSES(TH)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
        .req_chan(req_chan), .req_rank(req_rank), .req_bank(req_bank),
        .req_row(req_row), .window_done(window_done), .held_class(held_class),
        .held_accesses(held_accesses), .held_hits(held_hits));

    int nchk = 0, nfail = 0;
    bit done = 0;

    // bench model of private rows, accumulations and last latched values
    bit sv [8];
    int sr [8];
    int cur_acc [NC], cur_hit [NC], nxt_acc [NC], nxt_hit [NC];
    int last_acc [NC], last_hit [NC], last_cls [NC];

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_class(input int a, input int h);
        if (a < TH) return 0;
        if (2 * h < a) return 1;
        return 2;
    endfunction

    task automatic model_req(input int c, input int r, input int b, input int row, input bit to_next);
        int idx;
        bit h;
        idx = c * 4 + r * 2 + b;
        h = sv[idx] && (sr[idx] == row);
        sv[idx] = 1;
        sr[idx] = row;
        if (to_next) begin
            nxt_acc[c]++;
            if (h) nxt_hit[c]++;
        end else begin
            cur_acc[c]++;
            if (h) cur_hit[c]++;
        end
    endtask

    function automatic int pat_len(input int p);
        case (p)
            0: return 9;
            1: return 0;
            2: return 8;
            9: return 3;
            10: return 0;
            default: return 31;
        endcase
    endfunction

    task automatic gen(input int p, input int k, output bit v, output int c,
                       output int r, output int b, output int row);
        v = 1; c = 0; r = 0; b = 0; row = 0;
        if (p == 0) begin
            v = (k < 8);
            c = k % 2;
            row = (c == 0) ? 0 : ((k / 2) / 2 + 1);
        end else if (p == 2) begin
            if (k >= 3) begin c = 1; r = 1; b = 1; row = k - 3; end
        end else if (p == 9) begin
            r = 1; row = 6;
        end else begin
            v = ((k + p) % 7) != 0;
            c = (k ^ p) & 1;
            r = (k >> 1) & 1;
            b = ((k * p) >> 2) & 1;
            row = ((k * (p + 1)) / 5) & 7;
        end
    endtask

    task automatic check_held(input string tag_h);
        for (int c = 0; c < NC; c++) begin
            chk("R2 R8 accesses", int'(held_accesses[c*CW +: CW]), cur_acc[c]);
            chk(tag_h, int'(held_hits[c*CW +: CW]), cur_hit[c]);
            chk("R5 class", int'(held_class[2*c +: 2]), exp_class(cur_acc[c], cur_hit[c]));
            last_acc[c] = cur_acc[c];
            last_hit[c] = cur_hit[c];
            last_cls[c] = exp_class(cur_acc[c], cur_hit[c]);
            cur_acc[c] = nxt_acc[c];
            cur_hit[c] = nxt_hit[c];
            nxt_acc[c] = 0;
            nxt_hit[c] = 0;
        end
    endtask

    // starts at a falling edge 32 rising edges before the closing edge
    task automatic run_window(input int p, input bit late, input string tag_h);
        int n, s, c, r, b, row;
        bit v;
        n = pat_len(p);
        s = 0;
        for (int k = 0; k < n; k++) begin
            gen(p, k, v, c, r, b, row);
            req_valid = v; req_core = 1'(c); req_rank = 1'(r);
            req_bank = 1'(b); req_row = RW'(row); req_chan = '0;
            if (v) model_req(c, r, b, row, 0);
            @(negedge clk); s++;
        end
        req_valid = 1'b0;
        if (n <= 15) begin
            while (s < 16) begin @(negedge clk); s++; end
            for (int cc = 0; cc < NC; cc++) begin
                chk("R6 held mid-window", int'(held_accesses[cc*CW +: CW]), last_acc[cc]);
                chk("R6 held class mid-window", int'(held_class[2*cc +: 2]), last_cls[cc]);
            end
        end
        if (late) begin
            while (s < IV - 1) begin @(negedge clk); s++; end
            // R7: this request lands on the closing edge
            req_valid = 1'b1; req_core = 1'b1; req_rank = 1'b0; req_bank = 1'b1; req_row = 3'd3;
            model_req(1, 0, 1, 3, 1);
            @(negedge clk); s++;
            req_valid = 1'b0;
        end
        while (!window_done) begin @(negedge clk); s++; end
        chk("R1 window length", s, IV);
        check_held(tag_h);
    endtask

    // window timing monitor
    initial begin
        int gap;
        gap = 0;
        forever begin
            @(negedge clk);
            if (rst) gap = 0;
            else begin
                gap++;
                if (window_done) begin
                    chk("R1 pulse spacing", gap, IV);
                    gap = 0;
                end
            end
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin sv[i] = 0; sr[i] = 0; end
        for (int c = 0; c < NC; c++) begin
            cur_acc[c] = 0; cur_hit[c] = 0; nxt_acc[c] = 0; nxt_hit[c] = 0;
            last_acc[c] = 0; last_hit[c] = 0; last_cls[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R6 reset pulse", int'(window_done), 0);
        for (int c = 0; c < NC; c++) begin
            chk("R6 reset accesses", int'(held_accesses[c*CW +: CW]), 0);
            chk("R6 reset hits", int'(held_hits[c*CW +: CW]), 0);
            chk("R6 reset class", int'(held_class[2*c +: 2]), 0);
        end
        run_window(0, 0, "R4 first-access hits");
        run_window(1, 0, "R3 hits");
        run_window(2, 0, "R4 persisted hits");
        for (int p = 3; p <= 8; p++) run_window(p, 0, "R3 hits");
        run_window(9, 1, "R3 hits");
        run_window(10, 0, "R7 carried hits");
        run_window(1, 0, "R3 hits");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule